// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block watches for stalled software. It runs on a free-running watchdog clock and counts toward an interrupt timeout. Software picks that timeout from four powers of two. When the count reaches the timeout, the block raises a sticky interrupt flag and opens a grace window of fixed length. If software does not restart the watchdog before the window closes, and resets are enabled, the block drives an active-low reset pulse of fixed length. It also records that the watchdog was the source of the reset.

Software drives a restart strobe to clear the count and abandon any open window. It also has two clear strobes, one for each flag. The timeout select is captured only at a restart, and again when a reset pulse ends. An external active-low power-on reset returns everything to its idle state, with the shortest timeout selected. After the reset pulse, counting starts again from zero. Throughout this brief, "after N cycles" counts rising edges from the edge that samples the restart strobe.

Top module: `wdt_two_stage`

## Requirements
- R1: The select codes 0, 1, 2 and 3 on `tsel` choose a timeout of 2^(TO_BASE + TO_STEP*code) watchdog cycles. With the defaults this gives 2^12, 2^15, 2^18 and 2^21. `irq_flag` rises exactly that many cycles after the restart edge, and is low one cycle earlier.
- R2: `irq` is high exactly when `irq_flag` is set and `irq_en` is high.
- R3: Expiry opens a grace window of WIN_CYCLES cycles (default 512). If resets are enabled and the window closes, `wd_rst_n` falls exactly WIN_CYCLES cycles after `irq_flag` rose.
- R4: The reset pulse keeps `wd_rst_n` low for exactly RST_CYCLES cycles (default 8). A restart strobe during the pulse neither shortens it nor lengthens it.
- R5: `src_flag` is set on the same edge on which the reset pulse starts.
- R6: A restart strobe during the window cancels the window, and no reset pulse follows.
- R7: `irq_flag` stays set until `irq_clr` is pulsed. Clearing it does not cancel an open window.
- R8: A change of `tsel` between restarts does not alter the timeout currently being counted.
- R9: `src_flag` stays set through the end of the pulse and afterwards. Only `src_clr` or `por_n` low clears it. `por_n` low also clears `irq_flag` and releases `wd_rst_n`.
- R10: With `rst_en` low, the window still closes but no pulse occurs. Counting then restarts, and the next expiry follows the timeout after the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running watchdog clock |
| por_n | input | 1 | Asynchronous active-low power-on reset |
| tsel | input | 2 | Timeout select code, captured at restart |
| irq_en | input | 1 | Interrupt output enable |
| rst_en | input | 1 | Reset pulse enable |
| restart | input | 1 | One-cycle restart strobe |
| irq_clr | input | 1 | One-cycle clear strobe for `irq_flag` |
| src_clr | input | 1 | One-cycle clear strobe for `src_flag` |
| irq_flag | output | 1 | Sticky timeout-expired flag |
| src_flag | output | 1 | Sticky flag: watchdog caused a reset |
| irq | output | 1 | Interrupt request |
| wd_rst_n | output | 1 | Active-low reset pulse |

## Verification
The bench builds the block with TO_BASE=4, TO_STEP=1, WIN_CYCLES=16 and RST_CYCLES=8. This gives timeouts of 16, 32, 64 and 128 cycles. All four select codes can therefore be checked exactly to the edge, and each run stays short. The short window still puts every edge ordering within reach: a restart late in the window, a flag clear during the window, and a restart during the pulse. The pulse length keeps its default value, so the 8-cycle requirement is checked exactly as specified.

// File: rtl/wdt_two_stage.sv
module wdt_two_stage #(
  parameter int TO_BASE    = 12,
  parameter int TO_STEP    = 3,
  parameter int WIN_CYCLES = 512,
  parameter int RST_CYCLES = 8
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic [1:0] tsel,
  input  logic       irq_en,
  input  logic       rst_en,
  input  logic       restart,
  input  logic       irq_clr,
  input  logic       src_clr,
  output logic       irq_flag,
  output logic       src_flag,
  output logic       irq,
  output logic       wd_rst_n
);
  localparam int CW = TO_BASE + 3 * TO_STEP + 1;
  localparam logic [CW-1:0] WIN_LAST = CW'(WIN_CYCLES - 1);
  localparam logic [CW-1:0] RST_LAST = CW'(RST_CYCLES - 1);

  typedef enum logic [1:0] {S_RUN, S_WIN, S_RST} st_t;

  st_t           st;
  logic [1:0]    sel_q;
  logic [CW-1:0] cnt;
  logic [CW-1:0] to_last;

  always_comb begin
    to_last = '0;
    for (int i = 0; i < 4; i++)
      if (sel_q == 2'(i)) to_last = (CW'(1) << (TO_BASE + TO_STEP * i)) - CW'(1);
  end

  wire expire  = (st == S_RUN) && !restart && (cnt == to_last);
  wire win_end = (st == S_WIN) && !restart && (cnt == WIN_LAST);
  wire rst_end = (st == S_RST) && (cnt == RST_LAST);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      st    <= S_RUN;
      sel_q <= 2'd0;
      cnt   <= '0;
    end else begin
      case (st)
        S_RUN: begin
          if (restart) begin
            cnt   <= '0;
            sel_q <= tsel;
          end else if (expire) begin
            cnt <= '0;
            st  <= S_WIN;
          end else cnt <= cnt + CW'(1);
        end
        S_WIN: begin
          if (restart) begin
            cnt   <= '0;
            sel_q <= tsel;
            st    <= S_RUN;
          end else if (win_end) begin
            cnt <= '0;
            st  <= rst_en ? S_RST : S_RUN;
          end else cnt <= cnt + CW'(1);
        end
        default: begin
          if (rst_end) begin
            cnt   <= '0;
            sel_q <= tsel;
            st    <= S_RUN;
          end else cnt <= cnt + CW'(1);
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      irq_flag <= 1'b0;
      src_flag <= 1'b0;
    end else begin
      if (expire)       irq_flag <= 1'b1;
      else if (irq_clr) irq_flag <= 1'b0;
      if (win_end && rst_en) src_flag <= 1'b1;
      else if (src_clr)      src_flag <= 1'b0;
    end
  end

  assign irq      = irq_flag & irq_en;
  assign wd_rst_n = (st != S_RST);
endmodule

// File: rtl/wdt_two_stage_chk.sv
module wdt_two_stage_chk #(
  parameter int RST_CYCLES = 8
) (
  input logic clk,
  input logic por_n,
  input logic rst_en,
  input logic irq_clr,
  input logic src_clr,
  input logic irq_flag,
  input logic src_flag,
  input logic wd_rst_n
);
  logic [15:0] low_cnt;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)         low_cnt <= '0;
    else if (!wd_rst_n) low_cnt <= low_cnt + 16'd1;
    else                low_cnt <= '0;
  end

  AST_PULSE_LEN: assert property (@(posedge clk) disable iff (!por_n)
    $rose(wd_rst_n) |-> (low_cnt == 16'(RST_CYCLES))); // R4

  AST_SRC_AT_PULSE: assert property (@(posedge clk) disable iff (!por_n)
    $fell(wd_rst_n) |-> src_flag); // R5

  AST_PULSE_NEEDS_EN: assert property (@(posedge clk) disable iff (!por_n)
    $fell(wd_rst_n) |-> $past(rst_en)); // R10

  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!por_n)
    (irq_flag && !irq_clr) |=> irq_flag); // R7

  AST_SRC_STICKY: assert property (@(posedge clk) disable iff (!por_n)
    (src_flag && !src_clr) |=> src_flag); // R9
endmodule

bind wdt_two_stage wdt_two_stage_chk #(.RST_CYCLES(RST_CYCLES)) u_chk (
  .clk(clk), .por_n(por_n), .rst_en(rst_en), .irq_clr(irq_clr),
  .src_clr(src_clr), .irq_flag(irq_flag), .src_flag(src_flag),
  .wd_rst_n(wd_rst_n)
);

// File: tb/wdt_two_stage_bench.sv
`timescale 1ns/1ps
module wdt_two_stage_bench;
  localparam int TB_BASE = 4, TB_STEP = 1, TB_WIN = 16, TB_RST = 8;

  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic [1:0] tsel = 2'd0;
  logic irq_en = 1'b0, rst_en = 1'b0, restart = 1'b0, irq_clr = 1'b0, src_clr = 1'b0;
  logic irq_flag, src_flag, irq, wd_rst_n;
  int errs = 0, checks = 0;

  always #10 clk = ~clk;

  wdt_two_stage #(.TO_BASE(TB_BASE), .TO_STEP(TB_STEP), .WIN_CYCLES(TB_WIN),
                  .RST_CYCLES(TB_RST)) u_wdt_two_stage (
    .clk(clk), .por_n(por_n), .tsel(tsel), .irq_en(irq_en), .rst_en(rst_en),
    .restart(restart), .irq_clr(irq_clr), .src_clr(src_clr),
    .irq_flag(irq_flag), .src_flag(src_flag), .irq(irq), .wd_rst_n(wd_rst_n));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_restart();
    restart = 1'b1; @(negedge clk); restart = 1'b0;
  endtask

  task automatic do_irq_clr();
    irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;
  endtask

  task automatic do_src_clr();
    src_clr = 1'b1; @(negedge clk); src_clr = 1'b0;
  endtask

  function automatic int tlen(input int s);
    return 1 << (TB_BASE + TB_STEP * s);
  endfunction

  task automatic t_timeouts();
    rst_en = 1'b0;
    for (int s = 0; s < 4; s++) begin
      tsel = 2'(s);
      irq_en = (s % 2 == 0);
      do_restart();
      wait_n(tlen(s) - 1);
      chk("R1 flag before timeout", irq_flag, 0);
      wait_n(1);
      chk("R1 flag at timeout", irq_flag, 1);
      chk("R2 irq gated by enable", irq, (s % 2 == 0) ? 1 : 0);
      do_restart();
      do_irq_clr();
      chk("R7 flag cleared by strobe", irq_flag, 0);
      chk("R2 irq low with flag clear", irq, 0);
    end
    irq_en = 1'b0;
  endtask

  task automatic t_reset_pulse();
    int lows;
    rst_en = 1'b1; tsel = 2'd0;
    do_restart();
    wait_n(tlen(0));
    chk("R3 flag set", irq_flag, 1);
    wait_n(TB_WIN - 1);
    chk("R3 no pulse before window end", wd_rst_n, 1);
    wait_n(1);
    chk("R3 pulse at window end", wd_rst_n, 0);
    chk("R5 source flag with pulse", src_flag, 1);
    lows = 1;
    wait_n(2); lows += 2;
    do_restart(); lows += 1;
    while (wd_rst_n == 1'b0 && lows < 40) begin
      wait_n(1);
      if (wd_rst_n == 1'b0) lows++;
    end
    chk("R4 pulse length despite restart", lows, TB_RST);
    chk("R9 source flag kept after pulse", src_flag, 1);
    do_src_clr();
    chk("R9 source flag cleared by strobe", src_flag, 0);
    rst_en = 1'b0;
    do_restart();
    do_irq_clr();
  endtask

  task automatic t_cancel();
    int lows = 0;
    rst_en = 1'b1; tsel = 2'd0;
    do_restart();
    wait_n(tlen(0) + TB_WIN - 2);
    do_restart();
    for (int i = 0; i < tlen(0) + 4; i++) begin
      wait_n(1);
      if (!wd_rst_n) lows++;
    end
    chk("R6 no pulse after cancel", lows, 0);
    chk("R6 no source flag after cancel", src_flag, 0);
    rst_en = 1'b0;
    do_restart();
    do_irq_clr();
  endtask

  task automatic t_clear_keeps_window();
    rst_en = 1'b1; tsel = 2'd0;
    do_restart();
    wait_n(tlen(0));
    do_irq_clr();
    chk("R7 flag cleared mid window", irq_flag, 0);
    wait_n(TB_WIN - 1);
    chk("R7 pulse still occurs", wd_rst_n, 0);
    wait_n(TB_RST);
    rst_en = 1'b0;
    do_restart();
    do_src_clr();
    do_irq_clr();
  endtask

  task automatic t_sel_defer();
    rst_en = 1'b0; tsel = 2'd0;
    do_restart();
    tsel = 2'd3;
    wait_n(tlen(0) - 1);
    chk("R8 no early expiry", irq_flag, 0);
    wait_n(1);
    chk("R8 old timeout kept", irq_flag, 1);
    tsel = 2'd0;
    do_restart();
    do_irq_clr();
  endtask

  task automatic t_disabled();
    int lows = 0;
    rst_en = 1'b0; tsel = 2'd0;
    do_restart();
    wait_n(tlen(0));
    chk("R10 flag set", irq_flag, 1);
    do_irq_clr();
    for (int i = 0; i < tlen(0) + TB_WIN - 2; i++) begin
      wait_n(1);
      if (!wd_rst_n) lows++;
    end
    chk("R10 no pulse when disabled", lows, 0);
    chk("R10 no source flag", src_flag, 0);
    chk("R10 flag low before next expiry", irq_flag, 0);
    wait_n(1);
    chk("R10 next expiry after window", irq_flag, 1);
    do_restart();
    do_irq_clr();
  endtask

  task automatic t_por();
    rst_en = 1'b1; tsel = 2'd0;
    do_restart();
    wait_n(tlen(0) + TB_WIN + 2);
    chk("R9 source flag before power-on reset", src_flag, 1);
    por_n = 1'b0;
    #1;
    chk("R9 source flag cleared by power-on reset", src_flag, 0);
    chk("R9 irq flag cleared by power-on reset", irq_flag, 0);
    chk("R9 reset released by power-on reset", wd_rst_n, 1);
    @(negedge clk);
    por_n = 1'b1;
    rst_en = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    wait_n(3);
    chk("R9 reset state irq flag", irq_flag, 0);
    chk("R9 reset state source flag", src_flag, 0);
    chk("R2 reset state irq", irq, 0);
    chk("R4 reset state reset output", wd_rst_n, 1);
    por_n = 1'b1;
    wait_n(1);
    t_timeouts();
    t_reset_pulse();
    t_cancel();
    t_clear_keeps_window();
    t_sel_defer();
    t_disabled();
    t_por();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule